// File: doc/BRIEF.md
# Processor Debug Control Unit

This block sits between a debug register port and a processor core and lets an external debugger halt, resume, single-step and reset that core. Commands are issued by writing one-shot bits into a command register. The core's run state comes back through a status register. The debugger also reads the next instruction address and the machine state word from dedicated registers.

The core's register file is reached indirectly through an index register and a data register. The debugger writes a 6-bit register number to the index register. The unit drives that number onto the core's register-file read port, and the value the core returns is readable through the data register. Numbers 0 to 31 address the general registers. Numbers 32 and up address the fast special registers, starting with link and count; the numbering of that group is the core's concern.

Top module: `dbg_ctrl_unit`

## Requirements
- R1: Writing the command register (offset 0x10) with bit 0 set raises `halt_req`. The request stays high until a later command write clears it through start or step.
- R2: Command bit 4 (start) clears `halt_req`. If bit 0 and bit 4 are set in the same write, the halt wins and `halt_req` is high afterwards.
- R3: Command bit 1 produces a pulse on `core_rst_pulse` lasting exactly one cycle, in the cycle after the write. It also clears the sticky terminate flag.
- R4: Command bit 2 produces a pulse on `icache_rst_pulse` lasting exactly one cycle, in the cycle after the write.
- R5: Command bit 3 (step) has an effect only while the core is halted, meaning `halt_req` and `core_halted` are both high. In that case the unit drops `halt_req` until exactly one `core_retire` cycle has been seen, then raises it again. At any other time a step write leaves `halt_req` unchanged.
- R6: The status register (offset 0x11) reads back three fields: bit 0 is the halt request (stopping), bit 1 is `core_halted` (stopped) and bit 2 is the terminate flag. All other bits read 0. Writes to this register have no effect.
- R7: A cycle with `core_term` high sets the terminate flag. The flag stays set until a core-reset command clears it.
- R8: Offset 0x12 returns `core_nia` and offset 0x13 returns `core_msr`.
- R9: A write to offset 0x14 stores the low 6 bits of the written data as the register index, which is driven on `rf_idx`. A read of 0x14 returns the index zero-extended. A read of 0x15 returns `rf_rdata` for that index.
- R10: `bus_ack` and `bus_rdata` become valid in the cycle after a request. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access completed |
| bus_rdata | output | DATA_W | Read data |
| halt_req | output | 1 | Level request for the core to stop |
| core_halted | input | 1 | Core reports that it is stopped |
| core_retire | input | 1 | Core completed one instruction this cycle |
| core_term | input | 1 | Core signals termination |
| core_rst_pulse | output | 1 | One-cycle core reset |
| icache_rst_pulse | output | 1 | One-cycle instruction-cache reset |
| core_nia | input | DATA_W | Next instruction address |
| core_msr | input | DATA_W | Machine state word |
| rf_idx | output | IDX_W | Register-file read index |
| rf_rdata | input | DATA_W | Register-file read data |

## Verification
The bench builds the block with its default parameters: 8-bit offsets, 64-bit data, a 6-bit index and the registered read path. These values make the full index space of 64 registers reachable, including the truncation of wide index writes. The one-cycle read latency is also in play and must be allowed for when sampling. Because the data path is 64 bits wide, random address and machine-state values exercise the top bits of every read mux leg.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
   localparam int unsigned CMD_W = 5;
   localparam int unsigned STAT_W = 3;

   localparam logic [7:0] OFS_CMD  = 8'h10;
   localparam logic [7:0] OFS_STAT = 8'h11;
   localparam logic [7:0] OFS_NIA  = 8'h12;
   localparam logic [7:0] OFS_MSR  = 8'h13;
   localparam logic [7:0] OFS_IDX  = 8'h14;
   localparam logic [7:0] OFS_RFD  = 8'h15;

   localparam int unsigned CB_HALT  = 0;
   localparam int unsigned CB_CRST  = 1;
   localparam int unsigned CB_ICRST = 2;
   localparam int unsigned CB_STEP  = 3;
   localparam int unsigned CB_RUN   = 4;

   typedef struct packed {
      logic term;
      logic halted;
      logic halting;
   } dcu_stat_t;
endpackage

// File: rtl/dcu_cmd.sv
module dcu_cmd
   import dcu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_bits,
   input  logic             core_halted,
   input  logic             core_retire,
   input  logic             core_term,
   output logic             halt_q,
   output logic             crst_q,
   output logic             icrst_q,
   output logic             term_q
);
   logic arm_q;
   logic step_ok;

   assign step_ok = cmd_we && cmd_bits[CB_STEP] && halt_q && core_halted;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_q  <= 1'b0;
         arm_q   <= 1'b0;
         crst_q  <= 1'b0;
         icrst_q <= 1'b0;
         term_q  <= 1'b0;
      end else begin
         crst_q  <= cmd_we && cmd_bits[CB_CRST];
         icrst_q <= cmd_we && cmd_bits[CB_ICRST];
         if (core_term)
            term_q <= 1'b1;
         else if (cmd_we && cmd_bits[CB_CRST])
            term_q <= 1'b0;
         if (cmd_we && cmd_bits[CB_HALT]) begin
            halt_q <= 1'b1;
            arm_q  <= 1'b0;
         end else if (cmd_we && cmd_bits[CB_RUN]) begin
            halt_q <= 1'b0;
            arm_q  <= 1'b0;
         end else if (step_ok) begin
            halt_q <= 1'b0;
            arm_q  <= 1'b1;
         end else if (arm_q && core_retire) begin
            halt_q <= 1'b1;
            arm_q  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dcu_regmux.sv
module dcu_regmux
   import dcu_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IDX_W  = 6
)(
   input  logic [ADDR_W-1:0] addr,
   input  dcu_stat_t         stat,
   input  logic [DATA_W-1:0] nia,
   input  logic [DATA_W-1:0] msr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(OFS_STAT): rdata = DATA_W'(stat);
         ADDR_W'(OFS_NIA):  rdata = nia;
         ADDR_W'(OFS_MSR):  rdata = msr;
         ADDR_W'(OFS_IDX):  rdata = DATA_W'(idx);
         ADDR_W'(OFS_RFD):  rdata = rf_rdata;
         default:           rdata = '0;
      endcase
   end
endmodule

// File: rtl/dbg_ctrl_unit.sv
module dbg_ctrl_unit
   import dcu_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned IDX_W    = 6,
   parameter bit          READ_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_ack,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              halt_req,
   input  logic              core_halted,
   input  logic              core_retire,
   input  logic              core_term,
   output logic              core_rst_pulse,
   output logic              icache_rst_pulse,
   input  logic [DATA_W-1:0] core_nia,
   input  logic [DATA_W-1:0] core_msr,
   output logic [IDX_W-1:0]  rf_idx,
   input  logic [DATA_W-1:0] rf_rdata
);
   localparam int unsigned IDX_SPAN = 1 << IDX_W;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must hold the 8-bit register offsets");
      end
      if (DATA_W < CMD_W || DATA_W < IDX_W) begin : g_bad_data
         $error("DATA_W too narrow for command or index fields");
      end
      if (IDX_SPAN < 64) begin : g_bad_idx
         $error("IDX_W must reach all 64 register numbers");
      end
   endgenerate

   logic              cmd_wr;
   logic              idx_wr;
   logic              term_sticky;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] mux_data;
   dcu_stat_t         stat;

   assign cmd_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CMD));
   assign idx_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_IDX));

   dcu_cmd u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we      (cmd_wr),
      .cmd_bits    (bus_wdata[CMD_W-1:0]),
      .core_halted (core_halted),
      .core_retire (core_retire),
      .core_term   (core_term),
      .halt_q      (halt_req),
      .crst_q      (core_rst_pulse),
      .icrst_q     (icache_rst_pulse),
      .term_q      (term_sticky)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (idx_wr)
         idx_q <= bus_wdata[IDX_W-1:0];
   end

   assign rf_idx       = idx_q;
   assign stat.term    = term_sticky;
   assign stat.halted  = core_halted;
   assign stat.halting = halt_req;

   dcu_regmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
      .addr     (bus_addr),
      .stat     (stat),
      .nia      (core_nia),
      .msr      (core_msr),
      .idx      (idx_q),
      .rf_rdata (rf_rdata),
      .rdata    (mux_data)
   );

   generate
      if (READ_REG) begin : g_rd_reg
         logic              ack_q;
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ack_q <= 1'b0;
               rd_q  <= '0;
            end else begin
               ack_q <= bus_sel;
               rd_q  <= (bus_sel && !bus_we) ? mux_data : '0;
            end
         end
         assign bus_ack   = ack_q;
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_ack   = bus_sel;
         assign bus_rdata = (bus_sel && !bus_we) ? mux_data : '0;
      end
   endgenerate
endmodule

// File: rtl/dcu_chk.sv
module dcu_chk
   import dcu_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned IDX_W    = 6,
   parameter bit          READ_REG = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack,
   input logic              halt_req,
   input logic              core_halted,
   input logic              core_retire,
   input logic              core_term,
   input logic              core_rst_pulse,
   input logic              icache_rst_pulse,
   input logic [IDX_W-1:0]  rf_idx,
   input logic              term_sticky
);
   logic cmd_wr;
   logic idx_wr;
   assign cmd_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CMD));
   assign idx_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_IDX));

   AST_HALT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && !cmd_wr) |=> halt_req); // R1
   AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata[CB_HALT]) |=> halt_req); // R2
   AST_CRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_pulse |=> !core_rst_pulse); // R3
   AST_ICRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      icache_rst_pulse |=> !icache_rst_pulse); // R4
   AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata[CB_STEP] && !bus_wdata[CB_HALT] && !bus_wdata[CB_RUN]
       && !core_halted && !core_retire) |=> (halt_req == $past(halt_req))); // R5
   AST_TERM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      core_term |=> term_sticky); // R7
   AST_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_wr |=> $stable(rf_idx)); // R9

   generate
      if (READ_REG) begin : g_ack_chk
         AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            bus_sel |=> bus_ack); // R10
      end
   endgenerate
endmodule

bind dbg_ctrl_unit dcu_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .READ_REG(READ_REG)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .bus_sel          (bus_sel),
   .bus_we           (bus_we),
   .bus_addr         (bus_addr),
   .bus_wdata        (bus_wdata),
   .bus_ack          (bus_ack),
   .halt_req         (halt_req),
   .core_halted      (core_halted),
   .core_retire      (core_retire),
   .core_term        (core_term),
   .core_rst_pulse   (core_rst_pulse),
   .icache_rst_pulse (icache_rst_pulse),
   .rf_idx           (rf_idx),
   .term_sticky      (term_sticky)
);

// File: tb/sim_dbg_ctrl_unit.sv
module sim_dbg_ctrl_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic        bus_ack;
   logic [63:0] bus_rdata;
   logic        halt_req;
   logic        core_halted;
   logic        core_retire;
   logic        core_term = 1'b0;
   logic        core_rst_pulse;
   logic        icache_rst_pulse;
   logic [63:0] core_nia = '0;
   logic [63:0] core_msr = '0;
   logic [5:0]  rf_idx;
   logic [63:0] rf_rdata;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [63:0] rf_model(input logic [5:0] n);
      return 64'hA5A5_0000_0000_0000 ^ ({58'b0, n} * 64'h9E37_79B9_7F4A_7C15);
   endfunction

   // simple core model: stops one cycle after request, one instruction per running cycle
   always_ff @(posedge clk) begin
      if (!rst_n) core_halted <= 1'b0;
      else        core_halted <= halt_req;
   end
   assign core_retire = rst_n && !core_halted && !halt_req;
   assign rf_rdata = rf_model(rf_idx);

   dbg_ctrl_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .halt_req(halt_req), .core_halted(core_halted),
      .core_retire(core_retire), .core_term(core_term),
      .core_rst_pulse(core_rst_pulse), .icache_rst_pulse(icache_rst_pulse),
      .core_nia(core_nia), .core_msr(core_msr), .rf_idx(rf_idx), .rf_rdata(rf_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d, output logic ack);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata; ack = bus_ack;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic        ack;
      int          nret;
      void'($urandom(32'd1234));
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R1, R3, R4, R9, R10)
      check(!halt_req && !core_rst_pulse && !icache_rst_pulse, "R1 reset outputs",
            {61'b0, halt_req, core_rst_pulse, icache_rst_pulse}, 64'd0);
      check(rf_idx == 6'd0 && !bus_ack, "R9 reset index", {58'b0, rf_idx}, 64'd0);
      rd(8'h11, d, ack);
      check(d == 64'd0, "R6 reset status", d, 64'd0);
      check(ack == 1'b1, "R10 ack after read", {63'b0, ack}, 64'd1);

      // R1 halt and status
      wr(8'h10, 64'h1);
      check(halt_req == 1'b1, "R1 halt request", {63'b0, halt_req}, 64'd1);
      idle(5);
      check(halt_req == 1'b1, "R1 halt held", {63'b0, halt_req}, 64'd1);
      rd(8'h11, d, ack);
      check(d == 64'd3, "R6 status halted", d, 64'd3);

      // R5 single step: exactly one retired instruction, then halted again
      wr(8'h10, 64'h8);
      nret = 0;
      for (int i = 0; i < 10; i++) begin
         if (core_retire) nret++;
         @(negedge clk);
      end
      check(nret == 1, "R5 one instruction per step", 64'(nret), 64'd1);
      check(halt_req == 1'b1, "R5 halt after step", {63'b0, halt_req}, 64'd1);
      rd(8'h11, d, ack);
      check(d == 64'd3, "R6 status after step", d, 64'd3);

      // R2 start clears halt
      wr(8'h10, 64'h10);
      check(halt_req == 1'b0, "R2 start clears halt", {63'b0, halt_req}, 64'd0);
      rd(8'h11, d, ack);
      check(d == 64'd0, "R6 status running", d, 64'd0);

      // R5 step while running is ignored
      wr(8'h10, 64'h8);
      idle(6);
      check(halt_req == 1'b0, "R5 step ignored while running", {63'b0, halt_req}, 64'd0);

      // R2 halt and start together: halt wins
      wr(8'h10, 64'h11);
      check(halt_req == 1'b1, "R2 halt wins over start", {63'b0, halt_req}, 64'd1);
      wr(8'h10, 64'h10);

      // R3 and R4 pulses
      wr(8'h10, 64'h2);
      check(core_rst_pulse == 1'b1, "R3 reset pulse high", {63'b0, core_rst_pulse}, 64'd1);
      @(negedge clk);
      check(core_rst_pulse == 1'b0, "R3 reset pulse one cycle", {63'b0, core_rst_pulse}, 64'd0);
      wr(8'h10, 64'h4);
      check(icache_rst_pulse == 1'b1, "R4 icache pulse high", {63'b0, icache_rst_pulse}, 64'd1);
      @(negedge clk);
      check(icache_rst_pulse == 1'b0, "R4 icache pulse one cycle", {63'b0, icache_rst_pulse}, 64'd0);

      // R7 sticky terminate, cleared by core reset (R3)
      core_term = 1'b1;
      @(negedge clk);
      core_term = 1'b0;
      idle(3);
      rd(8'h11, d, ack);
      check(d[2] == 1'b1, "R7 terminate sticky", d, 64'd4);
      wr(8'h10, 64'h2);
      rd(8'h11, d, ack);
      check(d[2] == 1'b0, "R3 reset clears terminate", d, 64'd0);

      // R6 writes to status ignored
      wr(8'h11, '1);
      check(halt_req == 1'b0, "R6 status write ignored", {63'b0, halt_req}, 64'd0);
      rd(8'h11, d, ack);
      check(d == 64'd0, "R6 status unchanged", d, 64'd0);

      // R10 unmapped read
      rd(8'h20, d, ack);
      check(d == 64'd0, "R10 unmapped reads zero", d, 64'd0);

      // random index / register-file / NIA / MSR traffic (R8, R9)
      for (int k = 0; k < 40; k++) begin
         logic [63:0] v;
         logic [5:0]  n;
         v = {$urandom, $urandom};
         n = v[5:0];
         if (k == 0) begin v = 64'hFFFF_FFFF_FFFF_FFC0; n = 6'd0; end
         if (k == 1) begin v = 64'h0000_0000_0000_007F; n = 6'd63; end
         wr(8'h14, v);
         rd(8'h14, d, ack);
         check(d == {58'b0, n}, "R9 index truncated readback", d, {58'b0, n});
         rd(8'h15, d, ack);
         check(d == rf_model(n), "R9 register data", d, rf_model(n));
         core_nia = {$urandom, $urandom};
         core_msr = {$urandom, $urandom};
         rd(8'h12, d, ack);
         check(d == core_nia, "R8 next instruction address", d, core_nia);
         rd(8'h13, d, ack);
         check(d == core_msr, "R8 machine state", d, core_msr);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule